// File: doc/BRIEF.md
# Multi-Channel Reloadable Down Timer

A bank of six independent 32-bit down counters sits behind a 32-bit register port. The port has a flat byte address space. Each channel has a control word, an interval word and a current-value word, placed at a fixed 16-byte stride. Two shared words hold one interrupt-enable bit and one pending bit per channel. A channel counts down on tick enables taken from one of two external tick inputs, divided by a power-of-two prescaler. When it expires it raises its pending bit. It then either reloads from its interval word and keeps running, or stops and clears its own start bit. A single interrupt line combines all channels.

Software starts a channel by loading the interval and current words and then writing the control word with the start bit set. It services the interrupt by writing ones to the pending bits it has handled. The register port has no back-pressure. Every access completes in the cycle it is presented. A write takes effect at the next clock edge, and read data is combinational from the selected register.

Top module: `timer_bank`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Byte address 0x00 holds the interrupt enables and 0x04 the pending bits, with bit n belonging to channel n. Channel n has its control word at 0x10+0x10*n, its interval at 0x14+0x10*n and its current value at 0x18+0x10*n. The enable, interval and current words read back as written. The control word keeps bits 7:0 and reads zero above them. Any other address, including the stride slots of channels beyond the last, reads zero.
- R3: While control bit 0 (start) is 1, the current value drops by one on each divided tick. While start is 0, the current value holds, whatever the ticks do.
- R4: Control bits 6:4 hold a prescaler value p. The channel counts once per 2^p selected ticks. The divider restarts whenever the channel is stopped, so after a start the count after N selected ticks is the start value minus floor(N/2^p).
- R5: Control bits 3:2 select the tick: 01 selects `tick_osc`, and any other value selects `tick_alt`. The unselected input has no effect.
- R6: A divided tick that finds the current value at 1 or 0 is an expiry. It sets the channel's pending bit.
- R7: On expiry with control bit 1 (reload) at 1 and control bit 7 (single) at 0, the current value is loaded from the interval word and start stays 1.
- R8: On expiry with reload at 0 or single at 1, the current value becomes 0 and start is cleared, which is visible in the control word. Later ticks then change nothing.
- R9: Writing 0x04 clears each pending bit written as 1 and leaves bits written as 0 unchanged. An expiry in the same cycle as a clear of its bit leaves the bit set.
- R10: `irq` is high exactly when some channel has both its pending bit and its enable bit set.
- R11: A write to a current-value word loads it directly. It overrides a tick arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_osc | input | 1 | Tick enable selected by source code 01 |
| tick_alt | input | 1 | Tick enable selected by the other source codes |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Combined interrupt |

## Verification
The collision of interest is a channel expiring in the same clock edge that software writes the pending register to clear that channel's bit. The bench sets up a periodic channel one tick from expiry, with a second, already pending channel. It then presents one tick and a clear of both bits in the same cycle. The outcome is judged at the pending register: the second channel's bit must be gone, while the expiring channel's bit must survive, because the new event has to win over the old acknowledgement. A similar same-cycle race between a direct current-value write and a tick is judged by reading back the written value and then one further decrement.

// File: rtl/timer_pkg.sv
package timer_pkg;

  // Control word layout; bit positions are software visible.
  typedef struct packed {
    logic       single;  // bit 7: stop at expiry regardless of reload
    logic [2:0] pre;     // bits 6:4: divide by 2^pre
    logic [1:0] src;     // bits 3:2: tick source code
    logic       reload;  // bit 1: reload from interval at expiry
    logic       start;   // bit 0: channel running
  } tmr_ctrl_t;

  localparam int          CTRL_W     = $bits(tmr_ctrl_t);
  localparam logic [1:0]  SRC_OSC    = 2'b01;

  // Address map
  localparam logic [7:0]  OFS_IEN    = 8'h00;
  localparam logic [7:0]  OFS_IPEND  = 8'h04;
  localparam int          CH_BASE    = 'h10;
  localparam int          CH_STRIDE  = 'h10;
  localparam logic [3:0]  SUB_CTRL   = 4'h0;
  localparam logic [3:0]  SUB_INTV   = 4'h4;
  localparam logic [3:0]  SUB_CUR    = 4'h8;

endpackage

// File: rtl/timer_prescale.sv
module timer_prescale #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_tick,
  input  logic [PRE_W-1:0] pre,
  output logic             eff_tick
);

  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask     = ~({DIV_W{1'b1}} << pre);
    eff_tick = run && src_tick && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= '0;
    else if (!run)     div_q <= '0;
    else if (src_tick) div_q <= div_q + 1'b1;
  end

  // R4: the divider never advances while the channel is stopped
  div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> div_q == '0);

endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_pkg::*;
#(
  parameter int DW    = 32,
  parameter int PRE_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_osc,
  input  logic          tick_alt,
  input  logic          wr_ctrl,
  input  logic          wr_intv,
  input  logic          wr_cur,
  input  logic [DW-1:0] wdata,
  output tmr_ctrl_t     ctrl_q,
  output logic [DW-1:0] intv_q,
  output logic [DW-1:0] cur_q,
  output logic          expire
);

  logic src_tick;
  logic eff_tick;
  logic keep_going;
  logic at_end;

  always_comb begin
    src_tick   = (ctrl_q.src == SRC_OSC) ? tick_osc : tick_alt;
    keep_going = ctrl_q.reload && !ctrl_q.single;
    at_end     = (cur_q <= DW'(1));
    expire     = eff_tick && at_end;
  end

  timer_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_q.start),
    .src_tick (src_tick),
    .pre      (ctrl_q.pre),
    .eff_tick (eff_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
    end else if (expire && !keep_going) begin
      ctrl_q.start <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       intv_q <= '0;
    else if (wr_intv) intv_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (wr_cur) begin
      cur_q <= wdata;
    end else if (eff_tick) begin
      if (at_end) cur_q <= keep_going ? intv_q : '0;
      else        cur_q <= cur_q - 1'b1;
    end
  end

  // R3
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.start && !wr_cur) |=> $stable(cur_q));

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_tick && !at_end && !wr_cur) |=> cur_q == $past(cur_q) - 1'b1);

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && keep_going && !wr_cur && !wr_ctrl) |=> (cur_q == $past(intv_q)) && ctrl_q.start);

  // R8
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !keep_going && !wr_cur && !wr_ctrl) |=> (cur_q == '0) && !ctrl_q.start);

  // R11
  direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cur |=> cur_q == $past(wdata));

endmodule

// File: rtl/timer_irq_ctrl.sv
module timer_irq_ctrl #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_pend,
  input  logic [NCH-1:0] wdata,
  input  logic [NCH-1:0] set,
  output logic [NCH-1:0] en_q,
  output logic [NCH-1:0] pend_q,
  output logic           irq
);

  logic [NCH-1:0] clr;

  always_comb begin
    clr = wr_pend ? wdata : '0;
    irq = |(pend_q & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (wr_en) en_q <= wdata;
      pend_q <= (pend_q & ~clr) | set;
    end
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> (pend_q & $past(set)) == $past(set));

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> (pend_q & $past(wdata) & ~$past(set)) == '0);

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_pend && set == '0) |=> $stable(pend_q));

endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_pkg::*;
#(
  parameter int NCH   = 6,
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int PRE_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_osc,
  input  logic          tick_alt,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);

  localparam int SLOT_W = AW - 4;

  logic           wr_cyc;
  logic [3:0]     sub;
  logic [SLOT_W-1:0] slot;
  logic           hit_ien;
  logic           hit_pend;
  logic [NCH-1:0] ch_hit;
  logic [NCH-1:0] ch_expire;
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] pend_q;

  tmr_ctrl_t      ch_ctrl [NCH];
  logic [DW-1:0]  ch_intv [NCH];
  logic [DW-1:0]  ch_cur  [NCH];

  always_comb begin
    wr_cyc   = bus_sel && bus_wr;
    sub      = bus_addr[3:0];
    slot     = bus_addr[AW-1:4];
    hit_ien  = (bus_addr == AW'(OFS_IEN));
    hit_pend = (bus_addr == AW'(OFS_IPEND));
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_hit[g] = (slot == SLOT_W'((CH_BASE + CH_STRIDE * g) >> 4));

    timer_channel #(.DW(DW), .PRE_W(PRE_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_osc (tick_osc),
      .tick_alt (tick_alt),
      .wr_ctrl  (wr_cyc && ch_hit[g] && sub == SUB_CTRL),
      .wr_intv  (wr_cyc && ch_hit[g] && sub == SUB_INTV),
      .wr_cur   (wr_cyc && ch_hit[g] && sub == SUB_CUR),
      .wdata    (bus_wdata),
      .ctrl_q   (ch_ctrl[g]),
      .intv_q   (ch_intv[g]),
      .cur_q    (ch_cur[g]),
      .expire   (ch_expire[g])
    );
  end

  timer_irq_ctrl #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_cyc && hit_ien),
    .wr_pend (wr_cyc && hit_pend),
    .wdata   (bus_wdata[NCH-1:0]),
    .set     (ch_expire),
    .en_q    (en_q),
    .pend_q  (pend_q),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_ien)  bus_rdata = DW'(en_q);
    if (hit_pend) bus_rdata = DW'(pend_q);
    for (int i = 0; i < NCH; i++) begin
      if (ch_hit[i]) begin
        case (sub)
          SUB_CTRL: bus_rdata = DW'(ch_ctrl[i]);
          SUB_INTV: bus_rdata = ch_intv[i];
          SUB_CUR:  bus_rdata = ch_cur[i];
          default:  bus_rdata = '0;
        endcase
      end
    end
  end

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ((pend_q & en_q) != '0));

  // R2
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_hit));

endmodule

// File: tb/sim_timer_bank.sv
module sim_timer_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_osc = 1'b0;
  logic        tick_alt = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  timer_bank u0 (
    .clk(clk), .rst_n(rst_n), .tick_osc(tick_osc), .tick_alt(tick_alt),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [7:0] a_ctrl(int ch); return 8'(8'h10 + 8'h10 * ch); endfunction
  function automatic logic [7:0] a_intv(int ch); return 8'(8'h14 + 8'h10 * ch); endfunction
  function automatic logic [7:0] a_cur(int ch);  return 8'(8'h18 + 8'h10 * ch); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic irq_chk(string req, logic exp);
    @(negedge clk);
    #1 check(req, 32'(irq), 32'(exp));
  endtask

  task automatic ticks(logic o, logic a, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_osc = o; tick_alt = a;
      @(negedge clk); tick_osc = 1'b0; tick_alt = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state over the whole map
    for (int a = 0; a < 8'h70; a += 4) rd_chk("R1", 8'(a), 32'h0);
    irq_chk("R1 irq", 1'b0);

    // R2: readback and unmapped addresses
    wr(8'h00, 32'hFFFF_FF3F);
    rd_chk("R2 enable", 8'h00, 32'h0000_003F);
    for (int ch = 0; ch < 6; ch++) begin
      wr(a_intv(ch), (32'h1000_0001 * (ch + 1)) ^ 32'hA5A5_0000);
      wr(a_ctrl(ch), 32'hFFFF_FFF2);
      wr(a_cur(ch), 32'hDEAD_0000 + ch);
    end
    for (int ch = 0; ch < 6; ch++) begin
      rd_chk("R2 interval", a_intv(ch), (32'h1000_0001 * (ch + 1)) ^ 32'hA5A5_0000);
      rd_chk("R2 control", a_ctrl(ch), 32'h0000_00F2);
      rd_chk("R11 current", a_cur(ch), 32'hDEAD_0000 + ch);
      wr(a_ctrl(ch), 32'h0);
    end
    rd_chk("R2 unmapped", 8'h08, 32'h0);
    rd_chk("R2 unmapped", 8'h0C, 32'h0);
    rd_chk("R2 unmapped", 8'h1C, 32'h0);
    rd_chk("R2 unmapped", 8'h70, 32'h0);
    rd_chk("R2 unmapped", 8'h78, 32'h0);
    wr(8'h00, 32'h0);

    // R3: stopped channel holds
    wr(a_cur(0), 32'd10);
    wr(a_ctrl(0), 32'h04);
    ticks(1'b1, 1'b1, 5);
    rd_chk("R3 hold", a_cur(0), 32'd10);

    // R3 R4: prescaler sweep on every channel
    for (int ch = 0; ch < 6; ch++) begin
      for (int p = 0; p < 8; p++) begin
        int n;
        n = 13 + ch + 3 * p;
        wr(a_cur(ch), 32'd300);
        wr(a_ctrl(ch), 32'h05 | (p << 4));
        ticks(1'b1, 1'b0, n);
        rd_chk("R4 divide", a_cur(ch), 32'(300 - (n >> p)));
        wr(a_ctrl(ch), 32'h0);
      end
    end

    // R5: source select
    wr(a_cur(4), 32'd40);
    wr(a_ctrl(4), 32'h01);
    ticks(1'b1, 1'b0, 3);
    rd_chk("R5 src00 ignores osc", a_cur(4), 32'd40);
    ticks(1'b0, 1'b1, 2);
    rd_chk("R5 src00 alt", a_cur(4), 32'd38);
    wr(a_ctrl(4), 32'h09);
    ticks(1'b0, 1'b1, 2);
    rd_chk("R5 src10 alt", a_cur(4), 32'd36);
    wr(a_ctrl(4), 32'h0D);
    ticks(1'b0, 1'b1, 1);
    rd_chk("R5 src11 alt", a_cur(4), 32'd35);
    wr(a_ctrl(4), 32'h05);
    ticks(1'b0, 1'b1, 3);
    rd_chk("R5 src01 ignores alt", a_cur(4), 32'd35);
    ticks(1'b1, 1'b0, 1);
    rd_chk("R5 src01 osc", a_cur(4), 32'd34);
    wr(a_ctrl(4), 32'h0);

    // R6 R7 R9 R10: periodic channel
    wr(a_intv(2), 32'd3);
    wr(a_cur(2), 32'd3);
    wr(a_ctrl(2), 32'h07);
    ticks(1'b1, 1'b0, 2);
    rd_chk("R6 no early pend", 8'h04, 32'h0);
    rd_chk("R3 count", a_cur(2), 32'd1);
    ticks(1'b1, 1'b0, 1);
    rd_chk("R6 pend", 8'h04, 32'h04);
    rd_chk("R7 reload", a_cur(2), 32'd3);
    rd_chk("R7 start kept", a_ctrl(2), 32'h07);
    irq_chk("R10 masked", 1'b0);
    wr(8'h00, 32'h04);
    irq_chk("R10 enabled", 1'b1);
    wr(8'h04, 32'h3B);
    rd_chk("R9 zero bits ignored", 8'h04, 32'h04);
    wr(8'h04, 32'h04);
    rd_chk("R9 clear", 8'h04, 32'h0);
    irq_chk("R10 cleared", 1'b0);
    ticks(1'b1, 1'b0, 3);
    rd_chk("R7 second period", 8'h04, 32'h04);
    wr(a_ctrl(2), 32'h0);
    wr(8'h04, 32'h3F);
    wr(8'h00, 32'h0);

    // R8: single bit overrides reload; reload off stops too
    wr(a_intv(3), 32'd5);
    wr(a_cur(3), 32'd2);
    wr(a_ctrl(3), 32'h87);
    ticks(1'b1, 1'b0, 2);
    rd_chk("R8 single pend", 8'h04, 32'h08);
    rd_chk("R8 single cur", a_cur(3), 32'd0);
    rd_chk("R8 single stop", a_ctrl(3), 32'h86);
    ticks(1'b1, 1'b0, 1);
    rd_chk("R8 stays", a_cur(3), 32'd0);
    wr(a_intv(4), 32'd9);
    wr(a_cur(4), 32'd1);
    wr(a_ctrl(4), 32'h05);
    ticks(1'b1, 1'b0, 1);
    rd_chk("R8 noreload cur", a_cur(4), 32'd0);
    rd_chk("R8 noreload stop", a_ctrl(4), 32'h04);
    rd_chk("R8 pend", 8'h04, 32'h18);
    wr(8'h04, 32'h18);
    wr(a_ctrl(3), 32'h0);

    // R9: expiry and clear in the same cycle
    wr(a_cur(2), 32'd1);
    wr(a_ctrl(2), 32'h05);
    wr(a_intv(5), 32'd2);
    wr(a_cur(5), 32'd1);
    wr(a_ctrl(5), 32'h07);
    ticks(1'b1, 1'b0, 1);
    rd_chk("R6 two pend", 8'h04, 32'h24);
    ticks(1'b1, 1'b0, 1);
    rd_chk("R3 before race", a_cur(5), 32'd1);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h24; tick_osc = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick_osc = 1'b0;
    rd_chk("R9 set wins", 8'h04, 32'h20);
    rd_chk("R7 race reload", a_cur(5), 32'd2);
    wr(a_ctrl(5), 32'h0);
    wr(8'h04, 32'h3F);

    // R11: current write beats tick
    wr(a_cur(1), 32'd50);
    wr(a_ctrl(1), 32'h05);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a_cur(1); bus_wdata = 32'd7; tick_osc = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick_osc = 1'b0;
    rd_chk("R11 write wins", a_cur(1), 32'd7);
    ticks(1'b1, 1'b0, 1);
    rd_chk("R11 then counts", a_cur(1), 32'd6);
    wr(a_ctrl(1), 32'h0);

    // R10: enable sweep against a fixed pending pattern 0x2D
    for (int ch = 0; ch < 6; ch++) begin
      if ((32'h2D >> ch) & 1) begin
        wr(a_cur(ch), 32'd1);
        wr(a_ctrl(ch), 32'h05);
      end else begin
        wr(a_ctrl(ch), 32'h0);
      end
    end
    ticks(1'b1, 1'b0, 1);
    rd_chk("R6 pattern", 8'h04, 32'h2D);
    for (int e = 0; e < 64; e++) begin
      wr(8'h00, 32'(e));
      irq_chk("R10 sweep", (e & 32'h2D) != 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule